// File: doc/BRIEF.md
# Rolling Activate Window Limiter

This block guards row activation for one DRAM device at rank level. Every cycle it tells the command scheduler whether another ACTIVATE, to any bank of the device, may issue now. Two timing rules are enforced together. Consecutive activates must be at least `rrd_cfg_i` cycles apart. No more than four activates may fall inside any sliding span of `faw_cfg_i` cycles.

The scheduler samples `act_ok_o` combinationally in the cycle it wants to issue. It pulses `act_i` in the cycle an ACTIVATE actually goes out. A small circular history holds the issue times of the four most recent activates. The spacing rule is checked against the newest entry. The window rule is checked against the oldest entry, which is the slot the next activate will overwrite. If an activate is issued while the permit is low, a sticky violation flag is raised. The activate is still entered in the history, so later decisions stay true to what the device really saw.

Top module: `act_window_limiter`

## Requirements
- R1: After reset, `act_ok_o` is 1 and `viol_o` is 0 until an activate is issued.
- R2: If an activate is issued in cycle t, `act_ok_o` is 0 in cycles t+1 through t+rrd-1, where rrd is the current value of `rrd_cfg_i`. Values 0 and 1 allow activates back to back.
- R3: Once at least four activates have been recorded, `act_ok_o` is 0 while fewer than faw cycles have passed since the fourth most recent activate, where faw is the current value of `faw_cfg_i`.
- R4: The window slides with each new activate. After the fifth and later activates, the reference point is always the fourth most recent activate, not a fixed frame boundary.
- R5: While fewer than four activates have been recorded since reset, the window rule does not hold `act_ok_o` low.
- R6: An `act_i` pulse in a cycle where `act_ok_o` is 0 sets `viol_o` from the next cycle on, until reset. That activate is still recorded for both rules.
- R7: History entries older than the timestamp range are treated as fully expired. After an idle gap longer than 2^STAMP_W cycles, `act_ok_o` is 1.
- R8: `act_ok_o` reacts within the same cycle to a change on `rrd_cfg_i` or `faw_cfg_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | An ACTIVATE is issued this cycle |
| rrd_cfg_i | input | CFG_W | Minimum activate-to-activate spacing in cycles |
| faw_cfg_i | input | CFG_W | Length of the four-activate window in cycles |
| act_ok_o | output | 1 | Another ACTIVATE may issue this cycle |
| viol_o | output | 1 | Sticky: an activate was issued while not permitted |

## Verification
The hardest situation to reach is timestamp wrap-around. The stored times must keep meaning "long ago" after the free-running counter has lapped them. The bench builds the block with a narrow timestamp width, fills the history, and then stays idle for more than a full counter period before issuing again. Sliding-window behaviour is reached through a greedy scheduler that issues whenever permitted, under several spacing and window settings. A final phase issues activates regardless of the permit, so it covers violations and their recording.

// File: rtl/act_window_limiter.sv
module act_window_limiter #(
  parameter int CFG_W    = 8,
  parameter int STAMP_W  = 16,
  parameter int WIN_ACTS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [CFG_W-1:0] rrd_cfg_i,
  input  logic [CFG_W-1:0] faw_cfg_i,
  output logic             act_ok_o,
  output logic             viol_o
);
  localparam int PTR_W = (WIN_ACTS > 1) ? $clog2(WIN_ACTS) : 1;
  localparam int FILL_W = $clog2(WIN_ACTS + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(WIN_ACTS - 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(WIN_ACTS);
  localparam logic [STAMP_W-1:0] AGE_MAX = '1;

  logic [STAMP_W-1:0] now_q;
  logic [STAMP_W-1:0] stamp_q [WIN_ACTS];
  logic [STAMP_W-1:0] age [WIN_ACTS];
  logic [WIN_ACTS-1:0] stale_q;
  logic [PTR_W-1:0] wr_q, newest;
  logic [FILL_W-1:0] fill_q;
  logic rrd_ok, faw_ok, viol_q;

  for (genvar i = 0; i < WIN_ACTS; i++) begin : g_age
    assign age[i] = now_q - stamp_q[i];
  end

  assign newest   = (wr_q == '0) ? PTR_LAST : wr_q - 1'b1;
  assign rrd_ok   = (fill_q == '0) || stale_q[newest] ||
                    (age[newest] >= STAMP_W'(rrd_cfg_i));
  assign faw_ok   = (fill_q != FILL_FULL) || stale_q[wr_q] ||
                    (age[wr_q] >= STAMP_W'(faw_cfg_i));
  assign act_ok_o = rrd_ok && faw_ok;
  assign viol_o   = viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q   <= '0;
      wr_q    <= '0;
      fill_q  <= '0;
      stale_q <= '0;
      viol_q  <= 1'b0;
      for (int i = 0; i < WIN_ACTS; i++) stamp_q[i] <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      for (int i = 0; i < WIN_ACTS; i++)
        if (age[i] == AGE_MAX) stale_q[i] <= 1'b1;
      if (act_i) begin
        stamp_q[wr_q] <= now_q;
        stale_q[wr_q] <= 1'b0;
        wr_q          <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
        if (fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
        if (!act_ok_o) viol_q <= 1'b1;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk_i) !rst_ni |=> !viol_o);

  p_rrd_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(act_i) && rrd_cfg_i > 1 && $stable(rrd_cfg_i)) |-> !act_ok_o);

  p_viol_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !act_ok_o) |=> viol_o);

  p_viol_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);

endmodule

// File: tb/act_window_limiter_tb.sv
module act_window_limiter_tb_top;
  localparam int CFG_W = 6;
  localparam int STAMP_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act = 1'b0;
  logic [CFG_W-1:0] rrd_cfg = 6'd1;
  logic [CFG_W-1:0] faw_cfg = 6'd1;
  logic act_ok, viol;

  act_window_limiter #(.CFG_W(CFG_W), .STAMP_W(STAMP_W), .WIN_ACTS(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .act_i(act), .rrd_cfg_i(rrd_cfg),
    .faw_cfg_i(faw_cfg), .act_ok_o(act_ok), .viol_o(viol));

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int hist[$];
  bit viol_exp = 1'b0;
  logic [CFG_W-1:0] next_rrd = 6'd1;
  logic [CFG_W-1:0] next_faw = 6'd1;

  function automatic bit rrd_pass();
    return hist.size() == 0 || (cyc - hist[hist.size()-1]) >= int'(rrd_cfg);
  endfunction

  function automatic bit faw_pass();
    return hist.size() < 4 || (cyc - hist[hist.size()-4]) >= int'(faw_cfg);
  endfunction

  // mode: 0 idle, 1 issue when permitted (with chance), 2 issue always, 3 random
  task automatic step(input int mode, input string tag);
    bit exp_ok, want;
    string t;
    @(negedge clk);
    rrd_cfg = next_rrd;
    faw_cfg = next_faw;
    #1;
    exp_ok = rrd_pass() && faw_pass();
    if (tag != "") t = tag;
    else if (!rrd_pass()) t = "R2";
    else if (hist.size() < 4) t = "R5";
    else if (!faw_pass() && hist.size() > 4) t = "R4";
    else t = "R3";
    checks++;
    if (act_ok !== exp_ok) begin
      errors++;
      $display("FAIL %s permit act=%0b exp=%0b cyc=%0d", t, act_ok, exp_ok, cyc);
    end
    checks++;
    if (viol !== viol_exp) begin
      errors++;
      $display("FAIL R6 violation act=%0b exp=%0b cyc=%0d", viol, viol_exp, cyc);
    end
    case (mode)
      1: want = exp_ok && ($urandom_range(0, 3) != 0);
      2: want = 1'b1;
      3: want = ($urandom_range(0, 2) == 0);
      default: want = 1'b0;
    endcase
    act = want;
    if (want) begin
      if (!exp_ok) viol_exp = 1'b1;
      hist.push_back(cyc);
    end
    cyc++;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    // R1: reset state, then R5: four back-to-back acts with rrd=1, faw=20
    next_rrd = 6'd1; next_faw = 6'd20;
    step(0, "R1");
    for (int i = 0; i < 4; i++) step(2, "R5");
    for (int i = 0; i < 30; i++) step(0, "");
    // R2/R3/R4: greedy scheduling under several settings
    next_rrd = 6'd3; next_faw = 6'd16;
    for (int i = 0; i < 150; i++) step(1, "");
    next_rrd = 6'd5; next_faw = 6'd12;
    for (int i = 0; i < 120; i++) step(1, "");
    next_rrd = 6'd2; next_faw = 6'd40;
    for (int i = 0; i < 200; i++) step(1, "");
    next_rrd = 6'd0; next_faw = 6'd9;
    for (int i = 0; i < 100; i++) step(1, "");
    // R8: config changes seen in the same cycle
    for (int i = 0; i < 60; i++) begin
      next_rrd = 6'($urandom_range(0, 8));
      next_faw = 6'($urandom_range(0, 30));
      step(1, "R8");
    end
    // R7: fill history, then idle past the timestamp range
    next_rrd = 6'd4; next_faw = 6'd63;
    for (int i = 0; i < 40; i++) step(1, "");
    for (int i = 0; i < 600; i++) step(0, "R7");
    for (int i = 0; i < 100; i++) step(1, "R7");
    // R6: unrestricted issue, including violations that stay recorded
    next_rrd = 6'd3; next_faw = 6'd20;
    for (int i = 0; i < 300; i++) step(3, "");
    for (int i = 0; i < 40; i++) step(0, "R6");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule